// File: doc/BRIEF.md
# Ternary Select-Accumulate Matrix-Vector Unit

This unit forms one output row of a matrix-vector product at a time. The weights are ternary (-1, 0, +1) and arrive as 2-bit codes on a valid/ready stream, one code per cycle, column 0 first. Each code picks one of three actions on the signed 8-bit activation of its column: add it, subtract it, or leave the row sum alone. No per-element multiplier exists. The activations sit in a small register file that is loaded through a plain write port.

When the last code of a row is taken, the exact row sum is multiplied once by an unsigned fixed-point scale with 16 fractional bits, which is the weight scale and the activation scale combined. The product is rounded to the nearest integer, with halves going toward plus infinity. The result then leaves on a valid/ready output stream, and the accumulator starts the next row at zero.

Back-pressure follows two rules. The output holds its data while `res_valid` is high and `res_ready` is low. While a result waits in that state, `w_ready` is low, so no new code is taken. A code is taken on any rising edge where `w_valid` and `w_ready` are both high.

Top module: `ternary_mv_unit`

## Requirements
- R1: A taken weight code of 2'b01 adds the activation of its column to the row sum, 2'b11 subtracts it, and 2'b00 leaves the row sum unchanged.
- R2: A taken code of 2'b10 leaves the row sum unchanged and sets `code_err`. The flag stays set until reset.
- R3: The accumulator is signed and 8 + clog2(ROW_LEN) + 1 bits wide. Every row sum, including all -128 or all +127 activations, is exact.
- R4: `res_data` equals (row_sum * scale + 2^15) shifted arithmetically right by 16. `scale` is unsigned, with 16 fractional bits.
- R5: One code is taken per cycle while `w_ready` is high. `res_valid` rises on the cycle after the ROW_LEN-th code of a row is taken, and the next row starts from a zero sum.
- R6: While `res_valid` is high and `res_ready` is low, `res_data` stays stable and `w_ready` is low, so no code is taken.
- R7: Code number j of a row (j from 0) uses activation register j. A register written through `act_we`/`act_addr`/`act_wdata` holds the new value from the next cycle on.
- R8: After reset, `res_valid` and `code_err` are 0, `w_ready` is 1, and the next code taken is column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| act_we | input | 1 | Activation register write enable |
| act_addr | input | clog2(ROW_LEN) | Activation register index |
| act_wdata | input | 8 | Signed activation to write |
| scale | input | SCALE_W | Combined scale, unsigned, 16 fractional bits |
| w_valid | input | 1 | Weight code present |
| w_ready | output | 1 | Unit can take a code |
| w_code | input | 2 | Ternary weight code |
| res_valid | output | 1 | Row result present |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | OUT_W | Signed dequantized row result |
| code_err | output | 1 | Sticky flag for illegal code 2'b10 |

## Verification
The bench sweeps every ternary pattern of a 4-column row across activation sets that include all -128 and all +127. An accumulator that is too narrow or extends the wrong sign gives wrong sums there, and a swapped add/subtract code shows up at once. Scales of 1, 0.5 with sums of ±1, 1.5 and the largest scale test rounding. Rounding toward zero or truncating gives 0 where +1 is due, or -1 where 0 is due. A stall with a waiting code checks that the stalled code is taken exactly once and that the held result does not change. The illegal code is checked for a skip and for a flag that stays set, and an activation rewrite between rows checks the column mapping.

// File: rtl/tmv_pkg.sv
package tmv_pkg;

  typedef enum logic [1:0] {
    OP_SKIP = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } tern_op_e;

  localparam int ACT_W = 8;
  localparam int FRAC_BITS = 16;

endpackage

// File: rtl/tmv_act_rf.sv
module tmv_act_rf #(
  parameter int DEPTH = 8,
  parameter int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [AW-1:0]                 waddr,
  input  logic signed [tmv_pkg::ACT_W-1:0] wdata,
  input  logic [AW-1:0]                 raddr,
  output logic signed [tmv_pkg::ACT_W-1:0] rdata
);
  logic signed [tmv_pkg::ACT_W-1:0] regs [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs[i] <= '0;
      else if (we && (waddr == AW'(i))) regs[i] <= wdata;
    end
  end

  assign rdata = regs[raddr];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (regs[$past(waddr)] == $past(wdata)));  // R7
endmodule

// File: rtl/tmv_decode.sv
module tmv_decode
  import tmv_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      take,
  input  logic [1:0] code,
  output tern_op_e  op,
  output logic      err_flag
);
  logic bad;

  always_comb begin
    bad = 1'b0;
    case (code)
      2'b01:   op = OP_ADD;
      2'b11:   op = OP_SUB;
      2'b10: begin
        op  = OP_SKIP;
        bad = 1'b1;
      end
      default: op = OP_SKIP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_flag <= 1'b0;
    else if (take && bad) err_flag <= 1'b1;
  end

  AST_ERR_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && code == 2'b10) |=> err_flag);  // R2
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);  // R2
endmodule

// File: rtl/tmv_accum.sv
module tmv_accum
  import tmv_pkg::*;
#(
  parameter int ROW_LEN = 8,
  parameter int CW = (ROW_LEN > 1) ? $clog2(ROW_LEN) : 1,
  parameter int ACC_W = ACT_W + CW + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    take,
  input  tern_op_e                op,
  input  logic signed [ACT_W-1:0] act,
  output logic [CW-1:0]           col,
  output logic                    row_end,
  output logic signed [ACC_W-1:0] row_sum
);
  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] act_ext;
  logic signed [ACC_W-1:0] contrib;
  logic                    last_col;

  assign act_ext  = ACC_W'(act);
  assign last_col = (col == CW'(ROW_LEN - 1));
  assign row_end  = take && last_col;

  always_comb begin
    case (op)
      OP_ADD:  contrib = act_ext;
      OP_SUB:  contrib = -act_ext;
      default: contrib = '0;
    endcase
  end

  assign row_sum = acc_q + contrib;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      col   <= '0;
    end else if (take) begin
      if (last_col) begin
        acc_q <= '0;
        col   <= '0;
      end else begin
        acc_q <= row_sum;
        col   <= col + CW'(1);
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(acc_q) <= int'(col) * 128) && (int'(acc_q) >= -(int'(col) * 128)));  // R3
  AST_SKIP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && op == OP_SKIP && !last_col) |=> $stable(acc_q));  // R1
  AST_ROW_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    row_end |=> (acc_q == '0 && col == '0));  // R5
endmodule

// File: rtl/tmv_dequant.sv
module tmv_dequant
  import tmv_pkg::*;
#(
  parameter int ACC_W = 12,
  parameter int SCALE_W = 24,
  parameter int P_W = ACC_W + SCALE_W + 1,
  parameter int OUT_W = P_W - FRAC_BITS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic signed [ACC_W-1:0] sum,
  input  logic [SCALE_W-1:0]      scale,
  input  logic                    res_ready,
  output logic                    res_valid,
  output logic signed [OUT_W-1:0] res_data,
  output logic                    stall
);
  logic signed [P_W-1:0] sum_ext;
  logic signed [P_W-1:0] scl_ext;
  logic signed [P_W-1:0] prod;
  logic signed [P_W-1:0] rnd;
  logic signed [OUT_W-1:0] deq;

  assign sum_ext = P_W'(sum);
  assign scl_ext = $signed(P_W'(scale));
  assign prod    = P_W'(sum_ext * scl_ext);
  assign rnd     = prod + (P_W'(1) <<< (FRAC_BITS - 1));
  assign deq     = OUT_W'(rnd >>> FRAC_BITS);
  assign stall   = res_valid && !res_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else if (load) begin
      res_valid <= 1'b1;
      res_data  <= deq;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (res_valid && $stable(res_data)));  // R6
  AST_VALID_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> res_valid);  // R5
  AST_NO_LOAD_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !load);  // R6
endmodule

// File: rtl/ternary_mv_unit.sv
module ternary_mv_unit
  import tmv_pkg::*;
#(
  parameter int ROW_LEN = 8,
  parameter int SCALE_W = 24,
  localparam int CW = (ROW_LEN > 1) ? $clog2(ROW_LEN) : 1,
  localparam int ACC_W = ACT_W + CW + 1,
  localparam int OUT_W = ACC_W + SCALE_W + 1 - FRAC_BITS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    act_we,
  input  logic [CW-1:0]           act_addr,
  input  logic signed [ACT_W-1:0] act_wdata,
  input  logic [SCALE_W-1:0]      scale,
  input  logic                    w_valid,
  output logic                    w_ready,
  input  logic [1:0]              w_code,
  output logic                    res_valid,
  input  logic                    res_ready,
  output logic signed [OUT_W-1:0] res_data,
  output logic                    code_err
);
  logic                    take;
  logic                    stall;
  tern_op_e                op;
  logic [CW-1:0]           col;
  logic signed [ACT_W-1:0] act_rd;
  logic                    row_end;
  logic signed [ACC_W-1:0] row_sum;

  assign w_ready = !stall;
  assign take    = w_valid && w_ready;

  tmv_act_rf #(.DEPTH(ROW_LEN), .AW(CW)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(act_we), .waddr(act_addr),
    .wdata(act_wdata), .raddr(col), .rdata(act_rd)
  );

  tmv_decode u_dec (
    .clk(clk), .rst_n(rst_n), .take(take), .code(w_code),
    .op(op), .err_flag(code_err)
  );

  tmv_accum #(.ROW_LEN(ROW_LEN), .CW(CW), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .take(take), .op(op), .act(act_rd),
    .col(col), .row_end(row_end), .row_sum(row_sum)
  );

  tmv_dequant #(.ACC_W(ACC_W), .SCALE_W(SCALE_W), .P_W(ACC_W + SCALE_W + 1),
                .OUT_W(OUT_W)) u_dq (
    .clk(clk), .rst_n(rst_n), .load(row_end), .sum(row_sum), .scale(scale),
    .res_ready(res_ready), .res_valid(res_valid), .res_data(res_data),
    .stall(stall)
  );

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !w_ready);  // R6
endmodule

// File: tb/sim_ternary_mv_unit.sv
module sim_ternary_mv_unit;
  localparam int KB = 4;
  localparam int SW = 24;
  localparam int OW = 8 + 2 + 1 + SW + 1 - 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic act_we = 1'b0;
  logic [1:0] act_addr = '0;
  logic signed [7:0] act_wdata = '0;
  logic [SW-1:0] scale = '0;
  logic w_valid = 1'b0;
  logic w_ready;
  logic [1:0] w_code = 2'b00;
  logic res_valid;
  logic res_ready = 1'b1;
  logic signed [OW-1:0] res_data;
  logic code_err;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  longint acts [KB];

  always #5 clk = ~clk;

  ternary_mv_unit #(.ROW_LEN(KB), .SCALE_W(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .act_we(act_we), .act_addr(act_addr),
    .act_wdata(act_wdata), .scale(scale), .w_valid(w_valid), .w_ready(w_ready),
    .w_code(w_code), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .code_err(code_err)
  );

  task automatic chk(input bit ok, input string req, input longint got, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  function automatic longint deq(input longint s, input longint sc);
    longint p;
    p = s * sc + 32768;
    return p >>> 16;
  endfunction

  function automatic longint wval(input logic [1:0] c);
    case (c)
      2'b01: return 1;
      2'b11: return -1;
      default: return 0;
    endcase
  endfunction

  task automatic write_act(input int idx, input longint v);
    @(negedge clk);
    act_we = 1'b1; act_addr = 2'(idx); act_wdata = 8'(v);
    @(negedge clk);
    act_we = 1'b0;
    acts[idx] = v;
  endtask

  task automatic set_acts(input longint a0, input longint a1, input longint a2, input longint a3);
    write_act(0, a0); write_act(1, a1); write_act(2, a2); write_act(3, a3);
  endtask

  task automatic send_row(input logic [2*KB-1:0] codes, input string tag);
    longint s;
    s = 0;
    for (int j = 0; j < KB; j++) begin
      @(negedge clk);
      if (j == 1) chk(res_valid == 1'b0, "R5 no early valid", longint'(res_valid), 0);
      w_valid = 1'b1; w_code = codes[2*j +: 2];
      s += wval(codes[2*j +: 2]) * acts[j];
    end
    @(negedge clk);
    w_valid = 1'b0;
    chk(res_valid == 1'b1, "R5 valid after last", longint'(res_valid), 1);
    chk(longint'(res_data) == deq(s, longint'(scale)), tag, longint'(res_data), deq(s, longint'(scale)));
  endtask

  task automatic sweep(input string tag);
    for (int p = 0; p < 81; p++) begin
      logic [2*KB-1:0] c;
      int t;
      t = p;
      for (int j = 0; j < KB; j++) begin
        c[2*j +: 2] = (t % 3 == 0) ? 2'b00 : ((t % 3 == 1) ? 2'b01 : 2'b11);
        t = t / 3;
      end
      send_row(c, tag);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    longint held;
    for (int i = 0; i < KB; i++) acts[i] = 0;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(res_valid == 1'b0, "R8 res_valid", longint'(res_valid), 0);
    chk(code_err == 1'b0, "R8 code_err", longint'(code_err), 0);
    chk(w_ready == 1'b1, "R8 w_ready", longint'(w_ready), 1);
    rst_n = 1'b1;

    // R1 R3 R4 exhaustive code patterns over several activation sets
    scale = 24'd65536;
    set_acts(127, -128, 5, -7);
    sweep("R1 sum unit scale");
    scale = 24'd98304;
    set_acts(-128, -128, -128, -128);
    sweep("R3 all -128");
    scale = 24'hFFFFFF;
    set_acts(127, 127, 127, 127);
    sweep("R3 all +127 max scale");
    scale = 24'd32768;
    set_acts(1, -1, 0, 64);
    sweep("R4 half rounding");
    scale = 24'd1;
    set_acts(127, -128, 100, -100);
    sweep("R4 tiny scale");

    // R7: rewrite one register between rows
    scale = 24'd65536;
    write_act(2, -77);
    send_row(8'b00_01_00_00, "R7 new act used");

    // R6: back-pressure with a waiting code
    set_acts(127, -128, 5, -7);
    res_ready = 1'b0;
    for (int j = 0; j < KB; j++) begin
      @(negedge clk);
      w_valid = 1'b1; w_code = 2'b01;
    end
    @(negedge clk);
    w_code = 2'b01;
    held = longint'(res_data);
    chk(res_valid == 1'b1, "R6 result waiting", longint'(res_valid), 1);
    chk(held == deq(-3, 65536), "R6 result value", held, -3);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(w_ready == 1'b0, "R6 w_ready low", longint'(w_ready), 0);
      chk(longint'(res_data) == held && res_valid, "R6 data held", longint'(res_data), held);
    end
    res_ready = 1'b1;
    for (int j = 1; j < KB; j++) begin
      @(negedge clk);
      w_code = 2'b01;
    end
    @(negedge clk);
    w_valid = 1'b0;
    chk(res_valid == 1'b1, "R6 row after stall valid", longint'(res_valid), 1);
    chk(longint'(res_data) == -3, "R6 stalled code taken once", longint'(res_data), -3);

    // R2: illegal code skips and latches the flag
    @(negedge clk);
    chk(code_err == 1'b0, "R2 flag clear before", longint'(code_err), 0);
    send_row(8'b10_11_10_01, "R2 illegal code skips");
    chk(code_err == 1'b1, "R2 flag set", longint'(code_err), 1);
    send_row(8'b01_01_01_01, "R2 later row");
    repeat (2) @(negedge clk);
    chk(code_err == 1'b1, "R2 flag sticky", longint'(code_err), 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule